// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block is the control sequencer that sits in front of a small on-chip code flash while the flash is being programmed. An external programmer sets an address, a data byte and a two-bit operation code, then pulses an active-low program strobe. The block runs the requested operation on its own time base: it programs one byte, programs the protection bits, or erases the whole array. A ready output drops while an operation is running. The array is outside the block. It is reached through a simple port with an asynchronous read, a one-cycle byte write enable and a whole-array clear strobe.

Programming behaves like real flash cells. A byte program can only clear bits, so the stored value becomes the old contents ANDed with the new data. Only a full erase brings bits back to one. A programmer can poll a write that is still running: reading the byte being written returns its bit 7 inverted until the write is done. Three fixed signature locations identify the part and its programming-voltage variant. Two protection bits, once both are set, hide the code array from verify reads.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `ready` is 1, `dout` is FFh and neither `mem_we` nor `mem_clr` is asserted.
- R2: In program mode (`mode`=01), a high-to-low transition of `prog_n` sampled at a clock edge starts a byte write to the latched address. When it completes, the byte holds its previous value ANDed with the latched data.
- R3: `ready` goes low at the edge that samples the falling strobe and stays low for exactly WRITE_CYC cycles for a byte or lock program.
- R4: While a byte write runs, a verify read of the address being written returns the inverted bit 7 of the written data, with bits 6..0 taken from the stored byte, and a read of any other address returns FFh. After completion, reads return the true data.
- R5: A program operation never changes a stored 0 bit to 1.
- R6: In erase mode (`mode`=10), `prog_n` held low for ERASE_CYC cycles after the falling edge sets every byte to FFh and clears both protection bits. `ready` is low while the strobe is held.
- R7: Releasing `prog_n` before the erase time has elapsed ends the erase with the array unchanged.
- R8: A read with both `sel_n` bits low returns the signature: 1Eh at address 030h, 51h at 031h, and at 032h either FFh (SIG_HIGH_VOLT=1) or 05h (SIG_HIGH_VOLT=0). Other addresses return FFh. Signature reads work regardless of the protection bits.
- R9: In lock mode (`mode`=11), `din[0]` sets protection bit 1 and `din[1]` sets protection bit 2. Verify reads return FFh only when both bits are set.
- R10: A verify read (`mode`=00, `sel_n` not 00) registers its result, so `dout` shows the byte one clock after the address is applied. In any other mode `dout` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address |
| din | input | 8 | Data byte to program, or protection-bit selects |
| mode | input | 2 | Operation: 00 read, 01 program, 10 erase, 11 lock |
| sel_n | input | 2 | Both low selects signature reads |
| prog_n | input | 1 | Active-low program strobe |
| dout | output | 8 | Registered read data |
| ready | output | 1 | High when idle, low while an operation runs |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array byte write strobe |
| mem_clr | output | 1 | Array clear-to-FFh strobe |
| mem_rdata | input | 8 | Array read data (asynchronous) |

## Verification
The bench reprograms bytes that already hold data. A design that overwrote the byte instead of ANDing into it would show the new data instead of the combined value. It polls the byte under write at mid-operation. A design that skipped the polling inversion would return the stored bit 7, and one that leaked the array would return real data for other addresses. The bench also releases an erase early, which exposes a design that erases on the first strobe edge. It sets the protection bits one at a time, which catches a design that blocks reads after a single bit. Finally, it checks the busy width cycle by cycle, so an off-by-one in the timer shows up.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'b00,
    MD_PROG  = 2'b01,
    MD_ERASE = 2'b10,
    MD_LOCK  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01,
    ST_LOCK  = 2'b10,
    ST_ERASE = 2'b11
  } state_e;

  localparam logic [7:0] BLANK     = 8'hFF;
  localparam logic [7:0] SIG_VENDOR = 8'h1E;
  localparam logic [7:0] SIG_DEVICE = 8'h51;
  localparam logic [7:0] SIG_HV     = 8'hFF;
  localparam logic [7:0] SIG_LV     = 8'h05;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | en;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == (limit - CW'(1)));
endmodule

// File: rtl/fps_rdmux.sv
module fps_rdmux
  import fps_pkg::*;
#(
  parameter int AW            = 12,
  parameter bit SIG_HIGH_VOLT = 1'b1
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    sel_n,
  input  logic          reading,
  input  logic          busy,
  input  logic          poll_hit,
  input  logic          poll_d7,
  input  logic          blocked,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    rd_val
);
  localparam logic [AW-1:0] SIG_A0 = AW'(12'h030);
  localparam logic [AW-1:0] SIG_A1 = AW'(12'h031);
  localparam logic [AW-1:0] SIG_A2 = AW'(12'h032);
  localparam logic [7:0]    SIG_V  = SIG_HIGH_VOLT ? SIG_HV : SIG_LV;

  logic [7:0] sig_val;

  always_comb begin
    if      (addr == SIG_A0) sig_val = SIG_VENDOR;
    else if (addr == SIG_A1) sig_val = SIG_DEVICE;
    else if (addr == SIG_A2) sig_val = SIG_V;
    else                     sig_val = BLANK;
  end

  always_comb begin
    if (!reading)               rd_val = BLANK;
    else if (sel_n == 2'b00)    rd_val = sig_val;
    else if (busy)              rd_val = poll_hit ? {~poll_d7, mem_rdata[6:0]} : BLANK;
    else if (blocked)           rd_val = BLANK;
    else                        rd_val = mem_rdata;
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW            = 12,
  parameter int WRITE_CYC     = 750,
  parameter int ERASE_CYC     = 5000,
  parameter bit SIG_HIGH_VOLT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [1:0]    mode,
  input  logic [1:0]    sel_n,
  input  logic          prog_n,
  output logic [7:0]    dout,
  output logic          ready,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_clr,
  input  logic [7:0]    mem_rdata
);
  localparam int MAXC = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  state_e        state_q, state_d;
  logic [AW-1:0] lat_addr_q, lat_addr_d;
  logic [7:0]    lat_data_q, lat_data_d;
  logic [1:0]    lock_q, lock_d;
  logic          prog_q;
  logic [7:0]    dout_q, dout_d;
  logic          fall, tmr_en, tmr_clr, tmr_hit, idle;
  logic [CW-1:0] limit;
  mode_e         op;

  assign op      = mode_e'(mode);
  assign fall    = prog_q & ~prog_n;
  assign idle    = (state_q == ST_IDLE);
  assign tmr_clr = idle;
  assign limit   = (state_q == ST_ERASE) ? CW'(ERASE_CYC) : CW'(WRITE_CYC);

  fps_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .limit (limit),
    .hit   (tmr_hit)
  );

  always_comb begin
    state_d    = state_q;
    lat_addr_d = lat_addr_q;
    lat_data_d = lat_data_q;
    lock_d     = lock_q;
    tmr_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          unique case (op)
            MD_PROG: begin
              state_d    = ST_WRITE;
              lat_addr_d = addr;
              lat_data_d = din;
            end
            MD_LOCK: begin
              state_d    = ST_LOCK;
              lat_data_d = din;
            end
            MD_ERASE: state_d = ST_ERASE;
            MD_READ:  state_d = ST_IDLE;
          endcase
        end
      end
      ST_WRITE: begin
        tmr_en = 1'b1;
        if (tmr_hit) state_d = ST_IDLE;
      end
      ST_LOCK: begin
        tmr_en = 1'b1;
        if (tmr_hit) begin
          lock_d  = lock_q | lat_data_q[1:0];
          state_d = ST_IDLE;
        end
      end
      ST_ERASE: begin
        if (prog_n) begin
          state_d = ST_IDLE;
        end else begin
          tmr_en = 1'b1;
          if (tmr_hit) begin
            lock_d  = 2'b00;
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  assign mem_addr  = idle ? addr : lat_addr_q;
  assign mem_wdata = mem_rdata & lat_data_q;
  assign mem_we    = (state_q == ST_WRITE) & tmr_hit;
  assign mem_clr   = (state_q == ST_ERASE) & ~prog_n & tmr_hit;

  fps_rdmux #(.AW(AW), .SIG_HIGH_VOLT(SIG_HIGH_VOLT)) u_rdmux (
    .addr      (addr),
    .sel_n     (sel_n),
    .reading   (op == MD_READ),
    .busy      (~idle),
    .poll_hit  ((state_q == ST_WRITE) && (addr == lat_addr_q)),
    .poll_d7   (lat_data_q[7]),
    .blocked   (&lock_q),
    .mem_rdata (mem_rdata),
    .rd_val    (dout_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lock_q     <= 2'b00;
      prog_q     <= 1'b1;
      dout_q     <= BLANK;
    end else begin
      state_q    <= state_d;
      lat_addr_q <= lat_addr_d;
      lat_data_q <= lat_data_d;
      lock_q     <= lock_d;
      prog_q     <= prog_n;
      dout_q     <= dout_d;
    end
  end

  assign dout  = dout_q;
  assign ready = idle;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_n,
  input logic       ready,
  input logic       mem_we,
  input logic       mem_clr,
  input logic [7:0] mem_wdata,
  input logic [7:0] mem_rdata,
  input logic [1:0] lock_q
);
  AST_BUSY_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |-> !$past(prog_n)); // R3
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !ready); // R2
  AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> ready); // R3
  AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> ((mem_wdata & ~mem_rdata) == 8'h00)); // R5
  AST_CLEAR_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) mem_clr |-> (!prog_n && !ready)); // R6
  AST_CLEAR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n) mem_clr |=> (ready && lock_q == 2'b00)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !$past(mem_clr) |-> ((lock_q & $past(lock_q)) == $past(lock_q))); // R9
endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_n    (prog_n),
  .ready     (ready),
  .mem_we    (mem_we),
  .mem_clr   (mem_clr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .lock_q    (lock_q)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int AW = 12;
  localparam int WC = 8;
  localparam int EC = 20;
  localparam int NV = 6;
  // {addr, data, expected contents after program}
  localparam logic [27:0] VEC [NV] = '{
    {12'h000, 8'hA5, 8'hA5},
    {12'h001, 8'h3C, 8'h3C},
    {12'h7FF, 8'h00, 8'h00},
    {12'hFFF, 8'h81, 8'h81},
    {12'h000, 8'h0F, 8'h05},
    {12'h001, 8'hF0, 8'h30}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [1:0]    mode = 2'b00;
  logic [1:0]    sel_n = 2'b11;
  logic          prog_n = 1'b1;
  logic [7:0]    dout, mem_wdata, mem_rdata;
  logic          ready, mem_we, mem_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0]    fmem [1<<AW];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  flash_prog_seq #(.AW(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .SIG_HIGH_VOLT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode), .sel_n(sel_n),
    .prog_n(prog_n), .dout(dout), .ready(ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_clr(mem_clr), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = fmem[mem_addr];

  initial for (int i = 0; i < (1<<AW); i++) fmem[i] = 8'hFF;

  always @(posedge clk) begin
    if (mem_clr) for (int i = 0; i < (1<<AW); i++) fmem[i] <= 8'hFF;
    else if (mem_we) fmem[mem_addr] <= mem_wdata;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); mode = 2'b00; sel_n = s; addr = a;
    @(negedge clk); v = dout;
  endtask

  task automatic pulse(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] d, output int busy);
    @(negedge clk); mode = m; sel_n = 2'b11; addr = a; din = d; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; busy = 0;
    while (!ready && busy < 1000) begin @(negedge clk); busy++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int b;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ready", {7'b0, ready}, 8'h01);
    check("R1 dout", dout, 8'hFF);
    check("R1 strobes", {6'b0, mem_we, mem_clr}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5: table of programs, each reprogram ANDs
    for (int i = 0; i < NV; i++) begin
      pulse(2'b01, VEC[i][27:16], VEC[i][15:8], b);
      check("R3 busy width", 8'(b), 8'(WC));
      rd(VEC[i][27:16], 2'b11, v);
      check("R2 R5 stored", v, VEC[i][7:0]);
    end

    // R4: data polling during a write
    @(negedge clk); mode = 2'b01; addr = 12'h123; din = 8'hC3; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; mode = 2'b00; sel_n = 2'b11;
    @(negedge clk);
    check("R4 poll same addr", dout, 8'h7F);
    addr = 12'h000;
    @(negedge clk);
    check("R4 other addr busy", dout, 8'hFF);
    check("R3 still busy", {7'b0, ready}, 8'h00);
    addr = 12'h123;
    repeat (WC) @(negedge clk);
    check("R4 true data after", dout, 8'hC3);

    // R10: dout FF outside read mode
    @(negedge clk); mode = 2'b01; sel_n = 2'b11; addr = 12'h000;
    @(negedge clk);
    check("R10 non-read mode", dout, 8'hFF);

    // R7: early release aborts erase
    @(negedge clk); mode = 2'b10; prog_n = 1'b0;
    repeat (EC/2) @(negedge clk);
    check("R6 busy during erase", {7'b0, ready}, 8'h00);
    prog_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 ready after abort", {7'b0, ready}, 8'h01);
    rd(12'h000, 2'b11, v);
    check("R7 array kept", v, 8'h05);

    // R8: signature, low-voltage variant
    rd(12'h030, 2'b00, v); check("R8 sig 030", v, 8'h1E);
    rd(12'h031, 2'b00, v); check("R8 sig 031", v, 8'h51);
    rd(12'h032, 2'b00, v); check("R8 sig 032", v, 8'h05);
    rd(12'h033, 2'b00, v); check("R8 sig other", v, 8'hFF);

    // R9: protection bits
    pulse(2'b11, 12'h000, 8'h01, b);
    check("R3 lock busy width", 8'(b), 8'(WC));
    rd(12'h000, 2'b11, v); check("R9 one bit no block", v, 8'h05);
    pulse(2'b11, 12'h000, 8'h02, b);
    rd(12'h000, 2'b11, v); check("R9 both bits block", v, 8'hFF);
    rd(12'h030, 2'b00, v); check("R8 sig while locked", v, 8'h1E);

    // R6: full erase clears array and protection
    @(negedge clk); mode = 2'b10; prog_n = 1'b0;
    repeat (EC + 3) @(negedge clk);
    check("R6 ready after erase", {7'b0, ready}, 8'h01);
    prog_n = 1'b1;
    @(negedge clk);
    check("R6 no restart on hold", {7'b0, ready}, 8'h01);
    rd(12'h001, 2'b11, v); check("R6 erased 001", v, 8'hFF);
    rd(12'h7FF, 2'b11, v); check("R6 erased 7FF", v, 8'hFF);
    pulse(2'b01, 12'h010, 8'h77, b);
    rd(12'h010, 2'b11, v); check("R6 R9 unlocked reprogram", v, 8'h77);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule